// File: doc/BRIEF.md
# Two-Level Decoded Static Byte Memory

This block is a 32K-location by 8-bit static memory with a single address port, separate data-in and data-out buses, and three access controls: chip select, read enable and write enable. It is meant to be used as on-chip working storage that sits behind a simple synchronous request interface. Writes land on the rising clock edge. Read data comes out of a register one cycle after the request.

Inside, storage is not one flat array behind a 32K-output decoder. It is eight independent bit-planes, and each plane holds one bit position of every byte. Each plane is a 512-row by 64-column cell array. A shared row decoder turns the upper nine address bits into a one-hot row strobe that every plane uses. Each plane then picks one of its 64 row bits with the lower six address bits. Asserting both enables under chip select is an illegal request. The block turns it into a harmless cycle that writes nothing, forces the output byte to zero and raises an error flag.

Top module: `sram2l_top`

## Requirements
- R1: While reset is held, and on the first cycles after its release, `rd_data` is 0x00 and `clash_err` is 0.
- R2: A cycle with `sel`=1, `wr_en`=1 and `rd_en`=0 stores `wr_data` at `addr` on the rising edge.
- R3: A cycle with `sel`=1, `rd_en`=1 and `wr_en`=0 makes `rd_data` equal to the byte at `addr` from the next rising edge onward. Back-to-back reads each return their own byte, one cycle after being requested.
- R4: With `sel`=0, nothing is written and `rd_data` keeps its previous value, whatever `rd_en`, `wr_en`, `addr` and `wr_data` are.
- R5: With `sel`=1 and both enables 0, nothing is written and `rd_data` keeps its previous value.
- R6: A cycle with `sel`=1, `rd_en`=1 and `wr_en`=1 writes nothing. At the next edge `rd_data` becomes 0x00 and `clash_err` becomes 1 for exactly one cycle. `rd_data` then holds 0x00 until the next read.
- R7: `addr[14:6]` selects the row and `addr[5:0]` selects the column. Locations in the same row at adjacent columns, and in adjacent rows at the same column, are stored independently. The corner addresses 0x0000 and 0x7FFF are both usable.
- R8: All eight data bits are stored independently. The patterns 0x00, 0xFF, 0xA5 and 0x5A each read back unchanged.
- R9: `clash_err` is 0 after any cycle that is not a selected clash. This includes a cycle with both enables set while `sel`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel | input | 1 | Chip select; no access happens without it |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| addr | input | 15 | Byte address: row in [14:6], column in [5:0] |
| wr_data | input | 8 | Byte to be stored |
| rd_data | output | 8 | Registered read byte |
| clash_err | output | 1 | One-cycle flag for a selected read-and-write request |

## Verification
The bench builds the block at its default parameters: 9 row bits, 6 column bits and 8 data bits, which is the full 32K×8 arrangement. At these values the two corner addresses, neighbours across a row boundary and neighbours across a column boundary are all reachable with explicit addresses. This lets the tests show that the row field and the column field land in the right places. Full-width byte patterns exercise every bit-plane, and the clash, deselect and idle cycles are each followed by read-back of the location they could have disturbed.

// File: rtl/sram2l_pkg.sv
package sram2l_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_CLASH = 2'd3
  } acc_kind_t;

endpackage

// File: rtl/sram2l_ctrl.sv
module sram2l_ctrl
  import sram2l_pkg::*;
(
  input  logic      sel,
  input  logic      rd_en,
  input  logic      wr_en,
  output acc_kind_t kind,
  output logic      wr_stb
);

  always_comb begin
    kind = ACC_NONE;
    if (sel) begin
      unique case ({rd_en, wr_en})
        2'b10:   kind = ACC_READ;
        2'b01:   kind = ACC_WRITE;
        2'b11:   kind = ACC_CLASH;
        default: kind = ACC_NONE;
      endcase
    end
  end

  assign wr_stb = (kind == ACC_WRITE);

endmodule

// File: rtl/sram2l_row_dec.sv
module sram2l_row_dec #(
  parameter int ROW_BITS = 9,
  localparam int ROWS    = 1 << ROW_BITS
) (
  input  logic                en,
  input  logic [ROW_BITS-1:0] row,
  output logic [ROWS-1:0]     row_hit
);

  always_comb begin
    row_hit = '0;
    if (en) row_hit[row] = 1'b1;
  end

endmodule

// File: rtl/sram2l_plane.sv
module sram2l_plane #(
  parameter int ROW_BITS = 9,
  parameter int COL_BITS = 6,
  localparam int ROWS    = 1 << ROW_BITS,
  localparam int COLS    = 1 << COL_BITS
) (
  input  logic                clk,
  input  logic [ROWS-1:0]     row_hit,
  input  logic [ROW_BITS-1:0] rd_row,
  input  logic [COL_BITS-1:0] col,
  input  logic                bit_in,
  output logic                bit_out
);

  logic [COLS-1:0] cells [ROWS];
  logic [COLS-1:0] row_word;

  // Storage cells carry no reset, as in a real macro.
  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (row_hit[r]) cells[r][col] <= bit_in;
    end
  end

  // Read path: pick the row, then the column within it.
  always_comb begin
    row_word = cells[rd_row];
    bit_out  = row_word[col];
  end

endmodule

// File: rtl/sram2l_top.sv
module sram2l_top
  import sram2l_pkg::*;
#(
  parameter int ROW_BITS = 9,
  parameter int COL_BITS = 6,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = ROW_BITS + COL_BITS,
  localparam int ROWS    = 1 << ROW_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              clash_err
);

  logic [1:0]          rst_sync_q;
  logic                core_rst_n;
  acc_kind_t           kind;
  logic                wr_stb;
  logic [ROW_BITS-1:0] row_idx;
  logic [COL_BITS-1:0] col_idx;
  logic [ROWS-1:0]     row_hit;
  logic [DATA_W-1:0]   plane_bits;
  logic [DATA_W-1:0]   rd_data_q, rd_data_d;
  logic                err_q, err_d;
  logic                out_upd;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign row_idx = addr[ADDR_W-1:COL_BITS];
  assign col_idx = addr[COL_BITS-1:0];

  sram2l_ctrl u_ctrl (
    .sel    (sel),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .kind   (kind),
    .wr_stb (wr_stb)
  );

  sram2l_row_dec #(.ROW_BITS(ROW_BITS)) u_row_dec (
    .en      (wr_stb & core_rst_n),
    .row     (row_idx),
    .row_hit (row_hit)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_plane
    sram2l_plane #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_plane (
      .clk     (clk),
      .row_hit (row_hit),
      .rd_row  (row_idx),
      .col     (col_idx),
      .bit_in  (wr_data[b]),
      .bit_out (plane_bits[b])
    );
  end

  // Next-state logic for the output stage.
  always_comb begin
    rd_data_d = rd_data_q;
    err_d     = 1'b0;
    out_upd   = 1'b1;
    unique case (kind)
      ACC_READ:  rd_data_d = plane_bits;
      ACC_CLASH: begin
        rd_data_d = '0;
        err_d     = 1'b1;
      end
      default:   out_upd = err_q;
    endcase
  end

  // The data register loads only when out_upd is set.
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      rd_data_q <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q <= err_d;
      if (out_upd) rd_data_q <= rd_data_d;
    end
  end

  assign rd_data   = rd_data_q;
  assign clash_err = err_q;

endmodule

// File: rtl/sram2l_chk.sv
module sram2l_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              core_rst_n,
  input logic              sel,
  input logic              rd_en,
  input logic              wr_en,
  input logic              wr_stb,
  input logic [DATA_W-1:0] rd_data,
  input logic              clash_err
);

  logic clash;
  logic rd_req;
  assign clash  = sel && rd_en && wr_en;
  assign rd_req = sel && rd_en && !wr_en;

  AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (!core_rst_n)
    clash |=> clash_err) else $error("clash flag missing"); // R6

  AST_CLASH_ZERO: assert property (@(posedge clk) disable iff (!core_rst_n)
    clash |=> (rd_data == '0)) else $error("clash data not zero"); // R6

  AST_CLASH_NO_WRITE: assert property (@(posedge clk) disable iff (!core_rst_n)
    clash |-> !wr_stb) else $error("write strobe on clash"); // R6

  AST_DESELECT_NO_WRITE: assert property (@(posedge clk) disable iff (!core_rst_n)
    !sel |-> !wr_stb) else $error("write strobe while deselected"); // R4

  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!core_rst_n)
    !clash |=> !clash_err) else $error("spurious clash flag"); // R9

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!rd_req && !clash) |=> $stable(rd_data)) else $error("output moved without read"); // R5

endmodule

bind sram2l_top sram2l_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .sel        (sel),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .wr_stb     (wr_stb),
  .rd_data    (rd_data),
  .clash_err  (clash_err)
);

// File: tb/tb_sram2l_top.sv
module tb_sram2l_top;

  logic        clk;
  logic        rst_n;
  logic        sel, rd_en, wr_en;
  logic [14:0] addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic        clash_err;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  sram2l_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .clash_err (clash_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
    finish_run();
  end

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic check1(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Drive one request for one cycle, sample just after the capturing edge.
  task automatic cyc(logic s, logic r, logic w, logic [14:0] a, logic [7:0] d);
    @(negedge clk);
    sel = s; rd_en = r; wr_en = w; addr = a; wr_data = d;
    @(posedge clk);
    #1;
    sel = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(logic [14:0] a, logic [7:0] d);
    cyc(1'b1, 1'b0, 1'b1, a, d);
  endtask

  task automatic rd_chk(string req, logic [14:0] a, logic [7:0] exp);
    cyc(1'b1, 1'b1, 1'b0, a, 8'h00);
    check8(req, rd_data, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sel = 0; rd_en = 0; wr_en = 0; addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check8("R1 data in reset", rd_data, 8'h00);
    check1("R1 flag in reset", clash_err, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check8("R1 data after release", rd_data, 8'h00);
    check1("R1 flag after release", clash_err, 1'b0);
  endtask

  task automatic t_patterns();
    wr(15'h0000, 8'hA5);
    wr(15'h7FFF, 8'h5A);
    wr(15'h1234, 8'hFF);
    wr(15'h2000, 8'h00);
    wr(15'h2001, 8'hFF);
    rd_chk("R2 R8 corner 0x0000 pattern A5", 15'h0000, 8'hA5);
    rd_chk("R3 R8 corner 0x7FFF pattern 5A", 15'h7FFF, 8'h5A);
    rd_chk("R3 R8 pattern FF back-to-back", 15'h1234, 8'hFF);
    rd_chk("R8 pattern 00", 15'h2000, 8'h00);
    rd_chk("R2 rewrite neighbour", 15'h2001, 8'hFF);
  endtask

  task automatic t_neighbours();
    // row 5 col 10 = 0x14A, row 5 col 11 = 0x14B, row 6 col 10 = 0x18A
    wr(15'h014A, 8'h11);
    wr(15'h014B, 8'h22);
    wr(15'h018A, 8'h33);
    wr(15'h010A, 8'h44);   // row 4 col 10
    rd_chk("R7 row5 col10", 15'h014A, 8'h11);
    rd_chk("R7 row5 col11", 15'h014B, 8'h22);
    rd_chk("R7 row6 col10", 15'h018A, 8'h33);
    rd_chk("R7 row4 col10", 15'h010A, 8'h44);
    // Column field boundary: col 63 of row 0 vs col 0 of row 1
    wr(15'h003F, 8'h6C);
    wr(15'h0040, 8'h93);
    rd_chk("R7 row0 col63", 15'h003F, 8'h6C);
    rd_chk("R7 row1 col0", 15'h0040, 8'h93);
    rd_chk("R7 corner 0x0000 intact", 15'h0000, 8'hA5);
  endtask

  task automatic t_deselect();
    rd_chk("R3 preload read", 15'h014A, 8'h11);
    cyc(1'b0, 1'b0, 1'b1, 15'h014B, 8'h99);
    check8("R4 hold while deselected write", rd_data, 8'h11);
    check1("R9 no flag deselected", clash_err, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 15'h014B, 8'h99);
    check8("R4 hold deselected both enables", rd_data, 8'h11);
    check1("R9 no flag deselected both enables", clash_err, 1'b0);
    rd_chk("R4 target unchanged", 15'h014B, 8'h22);
  endtask

  task automatic t_idle();
    rd_chk("R3 preload read", 15'h018A, 8'h33);
    cyc(1'b1, 1'b0, 1'b0, 15'h018A, 8'hEE);
    check8("R5 hold selected idle", rd_data, 8'h33);
    check1("R9 no flag idle", clash_err, 1'b0);
    rd_chk("R5 target unchanged", 15'h018A, 8'h33);
  endtask

  task automatic t_clash();
    wr(15'h0100, 8'h3C);
    rd_chk("R3 preload read", 15'h0100, 8'h3C);
    cyc(1'b1, 1'b1, 1'b1, 15'h0100, 8'hC3);
    check8("R6 data zero after clash", rd_data, 8'h00);
    check1("R6 flag after clash", clash_err, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 15'h0000, 8'h00);
    check1("R6 flag lasts one cycle", clash_err, 1'b0);
    check8("R6 zero held after clash", rd_data, 8'h00);
    rd_chk("R6 no write on clash", 15'h0100, 8'h3C);
    check1("R9 flag low after read", clash_err, 1'b0);
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_neighbours();
    t_deselect();
    t_idle();
    t_clash();
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule